// File: doc/BRIEF.md
# Three-Wire Serial Command Slave with Hold-Off

This block is the peripheral end of a synchronous three-wire link. The host drives a serial clock and a command data line. The block answers on a single return line. The serial clock idles high. On each falling edge the block puts the next response bit on the return line, and on each rising edge it takes in one command bit. Bytes travel most significant bit first. Both serial inputs are brought into the system clock domain through synchronizer flops, and the block works on the edges it detects there.

The return line has two jobs. Between bytes it is a busy flag: high means wait, low means the host may start the next byte. During a byte it carries response data. After reset the line stays high for a parameterised self-test period. The first byte the host then sends is answered with a status byte that reflects the self-test input pin. After every received byte the line stays high for a parameterised processing time. The internal command logic sees each byte as a one-cycle strobe with data. It can queue the next response byte with a load pulse. When the self-test period ends, two active-low strap pins are latched into a display-memory pattern code.

Top module: `tw_hold_slave`

## Requirements
- R1: Command bits are taken from `sdi_i` on rising edges of `sclk_i`, first bit received being the MSB. After the 8th rising edge the assembled byte appears on `rx_data_o`.
- R2: On each falling edge of `sclk_i` during a transfer, `sdo_o` presents the next bit of the pending response, MSB first. The host reads it before the following rising edge.
- R3: While reset is asserted and for about SELFTEST_CYCLES system clocks after release, `sdo_o` is high and `rx_valid_o` is low. Then `sdo_o` goes low.
- R4: The response to the first byte after reset is 8'h01 if `selftest_ok_i` was high at the end of self-test, and 8'h55 if it was low.
- R5: `sdo_o` is high during exactly PROC_CYCLES system clocks, starting with the cycle in which `rx_valid_o` is high. It is low in the cycle that follows.
- R6: `rx_valid_o` is a single-cycle pulse, one per received byte.
- R7: A `rsp_load_i` pulse while the block is idle or in hold-off makes `rsp_data_i` the response to the next byte. With no load, the response is 8'h00.
- R8: A `rsp_load_i` pulse during a transfer has no effect on the response being shifted out or on the next one.
- R9: Serial clock edges during self-test or hold-off are ignored. They produce no strobe and do not disturb the next byte.
- R10: `pattern_o` equals {~strap_b_ni, ~strap_a_ni} sampled at the end of self-test. Code 0 (both straps high, the default) means all segments on at full brightness. After that, `pattern_o` holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles high |
| sdi_i | input | 1 | Command data from host |
| sdo_o | output | 1 | Busy flag between bytes, response data during a byte |
| selftest_ok_i | input | 1 | Self-test outcome, 1 = pass |
| strap_a_ni | input | 1 | Pattern strap A, active low |
| strap_b_ni | input | 1 | Pattern strap B, active low |
| pattern_o | output | 2 | Latched display-memory pattern code |
| rx_valid_o | output | 1 | Received-byte strobe |
| rx_data_o | output | DATA_W | Last received byte |
| rsp_load_i | input | 1 | Load next response byte |
| rsp_data_i | input | DATA_W | Next response byte |

## Verification
The bench builds the block with SELFTEST_CYCLES at 40 and PROC_CYCLES at 12 instead of their long defaults. This keeps a full reset-to-ready sequence, and an exact count of every hold-off window, to a few dozen clocks. The short windows are still wider than the synchronizer latency. Serial clock pulses can therefore be landed inside self-test and inside hold-off to show they are ignored. A load pulse can also be placed in hold-off ahead of the next byte. SYNC_STAGES stays at 2 and the host half-period is 4 system clocks, which puts every response bit on the line well before the host samples it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    ST_INIT,
    ST_READY,
    ST_XFER,
    ST_HOLD
  } tws_state_e;

  localparam logic [7:0] STATUS_PASS = 8'h01;
  localparam logic [7:0] STATUS_FAIL = 8'h55;

  localparam logic [1:0] PAT_ALL_BRIGHT = 2'd0;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int SELFTEST_CYCLES = 64,
  parameter int PROC_CYCLES     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              selftest_ok_i,
  input  logic              rsp_load_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              byte_done_i,
  output logic              shift_o,
  output logic              sample_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              latch_pat_o,
  output logic              busy_o,
  output logic              xfer_o
);
  localparam int MAXC = (SELFTEST_CYCLES > PROC_CYCLES) ? SELFTEST_CYCLES : PROC_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  tws_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic sclk_prev_q;
  logic rise, fall, init_end;

  assign rise     = sclk_s_i & ~sclk_prev_q;
  assign fall     = ~sclk_s_i & sclk_prev_q;
  assign init_end = (state_q == ST_INIT) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_INIT;
      cnt_q       <= CW'(SELFTEST_CYCLES - 1);
      sclk_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      unique case (state_q)
        ST_INIT: begin
          if (cnt_q == '0) state_q <= ST_READY;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_READY: if (fall) state_q <= ST_XFER;
        ST_XFER: begin
          if (byte_done_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= CW'(PROC_CYCLES - 1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_READY;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

  // edges outside a legal window are dropped
  assign shift_o  = fall && ((state_q == ST_READY) || (state_q == ST_XFER));
  assign sample_o = rise && (state_q == ST_XFER);

  assign load_o = init_end ||
                  (rsp_load_i && ((state_q == ST_HOLD) || ((state_q == ST_READY) && !fall)));
  assign load_data_o = init_end ? (selftest_ok_i ? DATA_W'(STATUS_PASS) : DATA_W'(STATUS_FAIL))
                                : rsp_data_i;

  assign latch_pat_o = init_end;
  assign busy_o      = (state_q == ST_INIT) || (state_q == ST_HOLD);
  assign xfer_o      = (state_q == ST_XFER);
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_s_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              byte_done_o,
  output logic              out_bit_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int BCW = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [BCW-1:0]    bit_cnt_q;

  assign byte_done_o = sample_i && (bit_cnt_q == BCW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q   <= '0;
      out_bit_o <= 1'b0;
    end else if (load_i) begin
      tx_sr_q <= load_data_i;
    end else if (shift_i) begin
      out_bit_o <= tx_sr_q[DATA_W-1];
      tx_sr_q   <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q    <= '0;
      bit_cnt_q  <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sample_i) begin
        rx_sr_q <= {rx_sr_q[DATA_W-2:0], sdi_s_i};
        if (byte_done_o) begin
          bit_cnt_q  <= '0;
          rx_valid_o <= 1'b1;
          rx_data_o  <= {rx_sr_q[DATA_W-2:0], sdi_s_i};
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tws_strap.sv
module tws_strap
  import tws_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       latch_i,
  input  logic       strap_a_ni,
  input  logic       strap_b_ni,
  output logic [1:0] pattern_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pattern_o <= PAT_ALL_BRIGHT;
    else if (latch_i) pattern_o <= {~strap_b_ni, ~strap_a_ni};
  end
endmodule

// File: rtl/tw_hold_slave.sv
module tw_hold_slave #(
  parameter int DATA_W          = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int SELFTEST_CYCLES = 5000,
  parameter int PROC_CYCLES     = 1300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              selftest_ok_i,
  input  logic              strap_a_ni,
  input  logic              strap_b_ni,
  output logic [1:0]        pattern_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rsp_load_i,
  input  logic [DATA_W-1:0] rsp_data_i
);
  logic sclk_s, sdi_s;
  logic shift, sample, load, latch_pat, busy, xfer, byte_done, out_bit;
  logic [DATA_W-1:0] load_data;

  tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s)
  );

  tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s)
  );

  tws_ctrl #(
    .DATA_W(DATA_W), .SELFTEST_CYCLES(SELFTEST_CYCLES), .PROC_CYCLES(PROC_CYCLES)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_s_i(sclk_s),
    .selftest_ok_i(selftest_ok_i), .rsp_load_i(rsp_load_i), .rsp_data_i(rsp_data_i),
    .byte_done_i(byte_done), .shift_o(shift), .sample_o(sample),
    .load_o(load), .load_data_o(load_data), .latch_pat_o(latch_pat),
    .busy_o(busy), .xfer_o(xfer)
  );

  tws_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdi_s_i(sdi_s),
    .shift_i(shift), .sample_i(sample), .load_i(load), .load_data_i(load_data),
    .byte_done_o(byte_done), .out_bit_o(out_bit),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  tws_strap u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .latch_i(latch_pat),
    .strap_a_ni(strap_a_ni), .strap_b_ni(strap_b_ni), .pattern_o(pattern_o)
  );

  // busy dominates; idle line low means clear to receive
  assign sdo_o = busy | (xfer & out_bit);
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
  parameter int PROC_CYCLES = 1300
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sdo_o,
  input logic       rx_valid_o,
  input logic [1:0] pattern_o
);
  localparam int HW = $clog2(PROC_CYCLES + 1);

  logic [HW-1:0] hold_cnt_q;
  logic          seen_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_q <= '0;
      seen_low_q <= 1'b0;
    end else begin
      if (!sdo_o) seen_low_q <= 1'b1;
      if (rx_valid_o)                                         hold_cnt_q <= HW'(1);
      else if (hold_cnt_q != '0 && hold_cnt_q < HW'(PROC_CYCLES)) hold_cnt_q <= hold_cnt_q + 1'b1;
      else                                                    hold_cnt_q <= '0;
    end
  end

  // R5
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sdo_o);
  // R5
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_cnt_q != '0 && hold_cnt_q < HW'(PROC_CYCLES)) |-> sdo_o);
  // R5
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_cnt_q == HW'(PROC_CYCLES)) |-> !sdo_o);
  // R6
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R3
  no_early_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_low_q |-> !rx_valid_o);
  // R10
  pattern_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_low_q |-> $stable(pattern_o));
endmodule

bind tw_hold_slave tws_chk #(.PROC_CYCLES(PROC_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o),
  .rx_valid_o(rx_valid_o), .pattern_o(pattern_o)
);

// File: tb/tw_hold_slave_tb.sv
module tw_hold_slave_tb;
  localparam int ST   = 40;
  localparam int PR   = 12;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdi = 1'b0, ok = 1'b1, sa_n = 1'b1, sb_n = 1'b1;
  logic rsp_load = 1'b0;
  logic [7:0] rsp_data = '0;
  logic sdo_o, rx_valid_o;
  logic [1:0] pattern_o;
  logic [7:0] rx_data_o;

  int n_run = 0, n_fail = 0;
  int valid_cnt = 0, last_hold = 0, hold_run = 0;
  bit in_hold = 1'b0;
  logic [7:0] last_rx = '0;

  always #10 clk = ~clk;

  tw_hold_slave #(.DATA_W(8), .SYNC_STAGES(2), .SELFTEST_CYCLES(ST), .PROC_CYCLES(PR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo_o),
    .selftest_ok_i(ok), .strap_a_ni(sa_n), .strap_b_ni(sb_n), .pattern_o(pattern_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rsp_load_i(rsp_load), .rsp_data_i(rsp_data)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      valid_cnt++;
      last_rx  = rx_data_o;
      in_hold  = 1'b1;
      hold_run = sdo_o ? 1 : 0;
    end else if (in_hold) begin
      if (sdo_o) hold_run++;
      else begin
        last_hold = hold_run;
        in_hold   = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic pass, input logic a_n, input logic b_n);
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b1; sdi = 1'b0; ok = pass; sa_n = a_n; sb_n = b_n;
    repeat (3) @(negedge clk);
    chk("R3 sdo in reset", int'(sdo_o), 1);
    chk("R3 strobe in reset", int'(rx_valid_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!sdo_o) break;
      n++;
    end
    if (sdo_o) chk("ready timeout", 1, 0);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit mid_load);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0; sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = sdo_o;
      if (mid_load && i == 4) begin
        rsp_load = 1'b1; rsp_data = 8'hFF;
        @(negedge clk);
        rsp_load = 1'b0;
      end
      sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic load_rsp(input logic [7:0] d);
    rsp_load = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_load = 1'b0;
  endtask

  task automatic t_reset_pass();
    int n;
    logic [7:0] r;
    int v0;
    apply_reset(1'b1, 1'b1, 1'b1);
    wait_ready(n);
    if (n < ST - 1 || n > ST) chk("R3 self-test busy length", n, ST - 1);
    else chk("R3 self-test busy length", 1, 1);
    chk("R10 default pattern all bright", int'(pattern_o), 0);
    v0 = valid_cnt;
    xfer(8'hA5, r, 1'b0);
    chk("R4 pass status", int'(r), 8'h01);
    wait_ready(n);
    chk("R1 rx byte", int'(last_rx), 8'hA5);
    chk("R6 one strobe", valid_cnt - v0, 1);
    chk("R5 hold length", last_hold, PR);
  endtask

  task automatic t_responses();
    int n;
    logic [7:0] r;
    xfer(8'h3C, r, 1'b0);
    chk("R7 default response", int'(r), 8'h00);
    wait_ready(n);
    chk("R1 rx byte 3C", int'(last_rx), 8'h3C);
    load_rsp(8'hC3);
    xfer(8'hFF, r, 1'b0);
    chk("R2 loaded response C3", int'(r), 8'hC3);
    load_rsp(8'h5A);  // lands in hold-off
    wait_ready(n);
    chk("R5 hold length again", last_hold, PR);
    xfer(8'h00, r, 1'b0);
    chk("R7 load during hold", int'(r), 8'h5A);
    wait_ready(n);
    chk("R1 rx byte 00", int'(last_rx), 8'h00);
  endtask

  task automatic t_mid_load();
    int n;
    logic [7:0] r;
    load_rsp(8'h96);
    xfer(8'h81, r, 1'b1);
    chk("R8 response kept", int'(r), 8'h96);
    wait_ready(n);
    xfer(8'h7E, r, 1'b0);
    chk("R8 next response unaffected", int'(r), 8'h00);
    wait_ready(n);
    chk("R1 rx byte 7E", int'(last_rx), 8'h7E);
  endtask

  task automatic t_fail_status();
    int n;
    logic [7:0] r;
    apply_reset(1'b0, 1'b1, 1'b1);
    wait_ready(n);
    xfer(8'h12, r, 1'b0);
    chk("R4 fail status", int'(r), 8'h55);
    wait_ready(n);
  endtask

  task automatic t_ignore();
    int n, v0;
    logic [7:0] r;
    apply_reset(1'b1, 1'b1, 1'b1);
    v0 = valid_cnt;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sclk = 1'b0; sdi = 1'b1;
      repeat (2) @(negedge clk); sclk = 1'b1;
      @(negedge clk);
    end
    wait_ready(n);
    chk("R9 no strobe in self-test", valid_cnt - v0, 0);
    xfer(8'h69, r, 1'b0);
    chk("R9 status after init edges", int'(r), 8'h01);
    @(negedge clk); sclk = 1'b0; sdi = 1'b1;
    @(negedge clk); sclk = 1'b1;
    wait_ready(n);
    chk("R9 rx after init edges", int'(last_rx), 8'h69);
    v0 = valid_cnt;
    xfer(8'h0F, r, 1'b0);
    wait_ready(n);
    chk("R9 rx after hold edges", int'(last_rx), 8'h0F);
    chk("R9 strobe count", valid_cnt - v0, 1);
  endtask

  task automatic t_straps();
    int n;
    for (int c = 0; c < 4; c++) begin
      apply_reset(1'b1, ~c[0], ~c[1]);
      wait_ready(n);
      chk("R10 pattern code", int'(pattern_o), c);
      sa_n = c[0]; sb_n = c[1];
      repeat (3) @(negedge clk);
      chk("R10 pattern held", int'(pattern_o), c);
    end
  endtask

  initial begin
    t_reset_pass();
    t_responses();
    t_mid_load();
    t_fail_status();
    t_ignore();
    t_straps();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule